// File: doc/BRIEF.md
# Serial-Link Watchdog Timer

This block watches a host that talks to the chip over a serial command link. Every received frame carries one watchdog bit. The host services the watchdog by flipping that bit from one frame to the next. A millisecond tick from outside drives an elapsed-time counter. If the counter reaches the selected period before the host flips the bit again, the block raises a timeout flag. The flag asks the rest of the chip to enter its fail-safe mode.

The period is chosen by a 2-bit code written through a configuration strobe. A written code does not take effect at once. It is held as pending and becomes active at the next watchdog toggle, so each count sequence runs against one fixed period. Frames that carry no command still service the watchdog when their bit flips. Decoding the frames and generating the tick happen outside this block.

Top module: `serial_link_watchdog`

## Requirements
- R1: Period codes map to tick counts as follows: code 2'b00 is 620, 2'b01 is 310, 2'b10 is 2500 and 2'b11 is 1250.
- R2: After reset the timeout flag is 0, the active and pending codes are 2'b00, the count is 0 and the remembered watchdog bit is 0.
- R3: A frame (frame_valid high) whose watchdog bit differs from the bit of the previous frame is a toggle. A toggle sets the count to 0 in that cycle, and a tick in the same cycle is not counted.
- R4: A frame whose watchdog bit equals the previous frame's bit does not restart the count.
- R5: A configuration write only updates the pending code. The active period changes only at a toggle, and it takes the code written in that same cycle if there is one.
- R6: A frame without a configuration write leaves the period codes unchanged, and it still services the watchdog when its bit toggles.
- R7: When a tick brings the count to the active period with no toggle in that cycle, timeout goes to 1 at that clock edge. It then stays at 1 until reset, whatever frames arrive.
- R8: While frame_valid is low, frame_wd_bit is ignored. It neither restarts the count nor changes the remembered bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per elapsed millisecond |
| frame_valid | input | 1 | A received frame is presented this cycle |
| frame_wd_bit | input | 1 | Watchdog bit of the presented frame |
| cfg_wr | input | 1 | Write strobe for the period configuration |
| cfg_period | input | 2 | Period code written with cfg_wr |
| timeout | output | 1 | Sticky timeout flag requesting fail-safe mode |

## Verification
Each result is registered once. A tick, frame or write presented in a cycle changes the count, the codes and the timeout flag at the next rising edge, so timeout reflects that stimulus one edge later. The bench drives all inputs on the falling edge and applies the same inputs to its own model at the rising edge. It compares timeout one time unit after that edge. A period of N ticks is then checked at both boundaries: the flag is still low after tick N-1 and high after tick N.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    PCODE_A = 2'b00,
    PCODE_B = 2'b01,
    PCODE_C = 2'b10,
    PCODE_D = 2'b11
  } swd_code_e;

  localparam int unsigned SWD_CNT_W_DEF = 12;

  // Selects one of four tick limits by period code.
  function automatic int unsigned swd_pick_limit(
    input logic [1:0]  code,
    input int unsigned lim_a,
    input int unsigned lim_b,
    input int unsigned lim_c,
    input int unsigned lim_d
  );
    int unsigned r;
    unique case (code)
      PCODE_A: r = lim_a;
      PCODE_B: r = lim_b;
      PCODE_C: r = lim_c;
      default: r = lim_d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/swd_toggle_detect.sv
module swd_toggle_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_valid,
  input  logic wd_bit,
  output logic toggle
);
  logic last_bit;

  assign toggle = frame_valid && (wd_bit != last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_bit <= 1'b0;
    else if (frame_valid) last_bit <= wd_bit;
  end

  // R8: the remembered bit only moves on a frame
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(last_bit));

  // R3: a toggle always flips the remembered bit
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (last_bit != $past(last_bit)));
endmodule

// File: rtl/swd_period_sel.sv
module swd_period_sel #(
  parameter int unsigned CNT_W = swd_pkg::SWD_CNT_W_DEF,
  parameter int unsigned LIM_A = 620,
  parameter int unsigned LIM_B = 310,
  parameter int unsigned LIM_C = 2500,
  parameter int unsigned LIM_D = 1250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_code,
  input  logic             toggle,
  output logic [CNT_W-1:0] limit
);
  import swd_pkg::*;

  logic [1:0] pending_code;
  logic [1:0] active_code;
  logic [1:0] next_pending;

  assign next_pending = cfg_wr ? cfg_code : pending_code;
  assign limit = CNT_W'(swd_pick_limit(active_code, LIM_A, LIM_B, LIM_C, LIM_D));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_code <= PCODE_A;
      active_code  <= PCODE_A;
    end else begin
      pending_code <= next_pending;
      if (toggle) active_code <= next_pending;
    end
  end

  // R5: the active period holds between toggles
  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle |=> $stable(active_code));

  // R5: a write coinciding with a toggle is applied at once
  assert_write_with_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && cfg_wr) |=> (active_code == $past(cfg_code)));

  // R6: without a write the pending code stays put
  assert_pending_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(pending_code));
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
  parameter int unsigned CNT_W = swd_pkg::SWD_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             toggle,
  input  logic [CNT_W-1:0] limit,
  output logic             timeout
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_inc;
  logic             advance;
  logic             expire;

  assign advance   = tick && !toggle && !timeout;
  assign count_inc = count + 1'b1;
  assign expire    = advance && (count_inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      timeout <= 1'b0;
    end else begin
      if (toggle)       count <= '0;
      else if (advance) count <= count_inc;
      if (expire)       timeout <= 1'b1;
    end
  end

  // R3: a toggle clears the count
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (count == '0));

  // R4: without a tick or toggle the count holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !tick) |=> $stable(count));

  // R7: the flag never drops once set
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);

  // R7: the flag rises exactly when the count meets the period
  assert_rise_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (count == limit));

  // R1: the count never runs past the active period
  assert_no_overrun_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= limit);
endmodule

// File: rtl/serial_link_watchdog.sv
module serial_link_watchdog #(
  parameter int unsigned CNT_W = swd_pkg::SWD_CNT_W_DEF,
  parameter int unsigned LIM_A = 620,
  parameter int unsigned LIM_B = 310,
  parameter int unsigned LIM_C = 2500,
  parameter int unsigned LIM_D = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       frame_valid,
  input  logic       frame_wd_bit,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_period,
  output logic       timeout
);
  logic             wd_toggle;
  logic [CNT_W-1:0] active_limit;

  swd_toggle_detect u_tog (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .wd_bit      (frame_wd_bit),
    .toggle      (wd_toggle)
  );

  swd_period_sel #(
    .CNT_W (CNT_W),
    .LIM_A (LIM_A),
    .LIM_B (LIM_B),
    .LIM_C (LIM_C),
    .LIM_D (LIM_D)
  ) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_code (cfg_period),
    .toggle   (wd_toggle),
    .limit    (active_limit)
  );

  swd_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_ms),
    .toggle  (wd_toggle),
    .limit   (active_limit),
    .timeout (timeout)
  );

  // R2: the flag is clear in the first cycle after reset
  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !timeout);
endmodule

// File: tb/sim_serial_link_watchdog.sv
`timescale 1ns/1ps
module sim_serial_link_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       frame_valid = 1'b0;
  logic       frame_wd_bit = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_period = 2'b00;
  logic       timeout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit       m_last;
  bit [1:0] m_pend, m_act;
  int       m_cnt;
  bit       m_to;

  always #5 clk = ~clk;

  serial_link_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .frame_valid(frame_valid),
    .frame_wd_bit(frame_wd_bit), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
    .timeout(timeout)
  );

  function automatic int ms_of(bit [1:0] c);
    if (c == 2'b01) return 310;
    if (c == 2'b11) return 1250;
    if (c == 2'b10) return 2500;
    return 620;
  endfunction

  task automatic chk(bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s timeout=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_last = 0; m_pend = 0; m_act = 0; m_cnt = 0; m_to = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_ms = 0; frame_valid = 0; cfg_wr = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle of stimulus, model update and check
  task automatic step(bit fv, bit b, bit wr, bit [1:0] code, bit tk, string req);
    bit tog;
    @(negedge clk);
    frame_valid = fv; frame_wd_bit = b; cfg_wr = wr; cfg_period = code; tick_ms = tk;
    @(posedge clk);
    tog = fv && (b != m_last);
    if (wr) m_pend = code;
    if (fv) m_last = b;
    if (tog) begin
      m_act = m_pend;
      m_cnt = 0;
    end else if (tk && !m_to) begin
      m_cnt++;
      if (m_cnt >= ms_of(m_act)) m_to = 1;
    end
    #1;
    chk(timeout, m_to, req);
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, req);
  endtask

  initial begin
    bit b;
    do_reset();
    chk(timeout, 1'b0, "R2");

    // R1/R2: default period 620
    ticks(619, "R2");
    chk(timeout, 1'b0, "R1");
    ticks(1, "R1");
    chk(timeout, 1'b1, "R1");

    // R5: write without toggle keeps 620
    do_reset();
    step(0, 0, 1, 2'b01, 0, "R5");
    ticks(400, "R5");
    chk(timeout, 1'b0, "R5");
    // R5: toggle with write of 01 -> 310
    do_reset();
    step(1, 1, 1, 2'b01, 1, "R5");
    ticks(309, "R5");
    chk(timeout, 1'b0, "R5");
    ticks(1, "R5");
    chk(timeout, 1'b1, "R5");

    // R4: same-bit frame does not restart
    do_reset();
    step(1, 1, 1, 2'b01, 0, "R4");
    ticks(200, "R4");
    step(1, 1, 0, 0, 0, "R4");
    ticks(110, "R4");
    chk(timeout, 1'b1, "R4");

    // R6: no-op toggles keep the watchdog alive, code unchanged (620)
    do_reset();
    b = 0;
    for (int k = 0; k < 4; k++) begin
      ticks(600, "R6");
      b = ~b;
      step(1, b, 0, 0, 1, "R6");
    end
    chk(timeout, 1'b0, "R6");
    ticks(619, "R6");
    chk(timeout, 1'b0, "R6");
    ticks(1, "R6");
    chk(timeout, 1'b1, "R6");

    // R8: bit changes without frame_valid ignored
    do_reset();
    ticks(300, "R8");
    step(0, 1, 0, 0, 1, "R8");
    ticks(319, "R8");
    chk(timeout, 1'b1, "R8");

    // R1: codes 10 and 11
    do_reset();
    step(1, 1, 1, 2'b10, 0, "R1");
    ticks(2499, "R1");
    chk(timeout, 1'b0, "R1");
    ticks(1, "R1");
    chk(timeout, 1'b1, "R1");
    do_reset();
    step(1, 1, 1, 2'b11, 0, "R1");
    ticks(1249, "R1");
    chk(timeout, 1'b0, "R1");
    ticks(1, "R1");
    chk(timeout, 1'b1, "R1");

    // R7: sticky through toggles; R3: toggle with tick not counted
    step(1, 0, 0, 0, 1, "R7");
    step(1, 1, 0, 0, 1, "R7");
    ticks(5, "R7");
    chk(timeout, 1'b1, "R7");
    do_reset();
    ticks(619, "R3");
    step(1, 1, 0, 0, 1, "R3");
    chk(timeout, 1'b0, "R3");
    ticks(619, "R3");
    chk(timeout, 1'b0, "R3");
    ticks(1, "R3");
    chk(timeout, 1'b1, "R3");

    // constrained random phases, fixed seed
    void'($urandom(32'h5eed_1234));
    for (int ph = 0; ph < 6; ph++) begin
      int fprob;
      do_reset();
      fprob = (ph % 2 == 0) ? 8 : 3000;
      for (int i = 0; i < 7000; i++) begin
        bit fv, wr;
        fv = ($urandom % fprob) == 0;
        wr = ($urandom % 16) == 0;
        step(fv, 1'($urandom), wr, 2'($urandom), ($urandom % 4) != 0, "R3");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired, no requirement completed");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule